// File: doc/BRIEF.md
# Parallel OR-and-Store Execute Unit

This unit is the execute stage for one dual-operation instruction. In a single cycle it performs two independent actions taken from the same operand word. The first is a bitwise OR of a general register with a second operand, and the result goes to a destination register. The second operand is normally a word read from memory through an indirect address. The second action stores a general register, as a full word, to a second indirectly addressed location. The unit contains eight 32-bit general registers (R0..R7), eight address pointers (P0..P7), two index registers (X0, X1), and one address generator for each memory access. It connects to a data memory that has one combinational read port and one write port, which commits on the clock edge.

Every register and memory operand is taken from the state that exists at the start of the cycle. All results commit together at the closing edge. A store whose source register is also the OR destination therefore writes the value from before the OR. When the read address equals the write address, the OR sees the memory word from before the store. Instruction fetch and opcode decode are handled upstream. The `instr` port carries only the 25 operand bits. A separate load port represents write-back from other units and is used to initialise the registers.

Top module: `orst_par_exec`

## Requirements
- R1: While `issue` is high, `wb_valid` is high and `wb_data` equals (value of source register `instr[24:22]`) OR (second operand); the destination register `instr[21:19]` holds `wb_data` after the clock edge.
- R2: While `issue` is high, `mem_we` is high and `mem_wdata` equals the value of register `instr[18:16]` at the start of the cycle.
- R3: If the store source register equals the OR destination register, `mem_wdata` is the register value from before the OR result is written.
- R4: If the read and write addresses are equal, the OR uses the memory word from before the store, and the stored word is in memory afterwards.
- R5: Each indirect operand is 5 bits: a pointer select in bits [4:2] and a displacement select in bits [1:0] (00 = 0, 01 = 1, 10 = X0, 11 = X1). The address is (pointer + displacement) modulo 2^ADDR_W. The read operand is `instr[15:11]` and drives `mem_raddr`; the write operand is `instr[10:6]` and drives `mem_waddr`.
- R6: `wb_idx` equals the destination field `instr[21:19]`.
- R7: If `instr[5]` is 1, the second operand is the register named by `instr[4:0]` (0..7 = R0..R7, 8..15 = P0..P7, 16 = X0, 17 = X1, others read zero), and `mem_re` is low; if `instr[5]` is 0, `mem_re` is high.
- R8: After an issue cycle, `flag_z` is 1 exactly when the OR result is zero, and `flag_n` equals bit 31 of the result. Cycles without issue leave both flags unchanged.
- R9: When `ld_en` is high and `issue` is low, the register selected by `ld_sel` (same encoding as R7) takes `ld_data` at the edge. A load presented while `issue` is high has no effect.
- R10: Synchronous active-low reset clears all registers and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Execute the operand word this cycle |
| instr | input | 25 | Operand fields of the instruction |
| ld_en | input | 1 | Register load from other units |
| ld_sel | input | 5 | Register selected for load |
| ld_data | input | 32 | Load value |
| mem_re | output | 1 | Memory read enable |
| mem_raddr | output | ADDR_W | Read address |
| mem_rdata | input | 32 | Read data, same cycle |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | ADDR_W | Write address |
| mem_wdata | output | 32 | Write data |
| wb_valid | output | 1 | Register write-back this cycle |
| wb_idx | output | 3 | Write-back register |
| wb_data | output | 32 | OR result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The hardest cases to reach are the collisions, where one instruction reads a register or memory word that the same instruction overwrites. The ports show these collisions only through the data values that result. The vector table therefore contains words where the store source equals the OR destination. It also contains words whose two indirect fields resolve to the same address, using the same pointer and the same displacement select. A later word reads back a location written earlier, so the test shows that a stored value is committed only at the edge. A load presented in the same cycle as an issue is checked through a later store of the register it targeted.

// File: rtl/orst_pkg.sv
// Shared field layout and encodings for the parallel OR-and-store unit.
// Assumes the opcode has been stripped upstream; only operand bits arrive.
package orst_pkg;
    localparam int NUM_GPR  = 8;
    localparam int NUM_PTR  = 8;
    localparam int RIDX_W   = $clog2(NUM_GPR);
    localparam int PIDX_W   = $clog2(NUM_PTR);
    localparam int SEL_W    = 5;
    localparam int SEL_PTR0 = NUM_GPR;
    localparam int SEL_X0   = NUM_GPR + NUM_PTR;
    localparam int SEL_X1   = SEL_X0 + 1;
    localparam int MODE_BIT = 5;

    typedef enum logic [1:0] {
        DISP_ZERO = 2'b00,
        DISP_ONE  = 2'b01,
        DISP_X0   = 2'b10,
        DISP_X1   = 2'b11
    } disp_sel_e;

    typedef struct packed {
        logic [PIDX_W-1:0] ptr;
        disp_sel_e         disp;
    } ind_t;

    typedef struct packed {
        logic [RIDX_W-1:0] src1;
        logic [RIDX_W-1:0] dst1;
        logic [RIDX_W-1:0] src3;
        ind_t              rd_ind;
        ind_t              wr_ind;
        logic              reg_mode;
        logic [SEL_W-1:0]  src2_sel;
    } opw_t;

    localparam int OPW_W = $bits(opw_t);
endpackage

// File: rtl/orst_regfile.sv
// Register state: general registers, address pointers and index registers.
// Assumes all reads are combinational from flops, so every read returns
// the value from the start of the cycle. A commit has priority over a load;
// a load presented during a commit cycle is dropped.
module orst_regfile
    import orst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cm_en,
    input  logic [RIDX_W-1:0] cm_idx,
    input  logic [DATA_W-1:0] cm_data,
    input  logic              ld_en,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [RIDX_W-1:0] rb_idx,
    input  logic [SEL_W-1:0]  rc_sel,
    input  logic [PIDX_W-1:0] pa_idx,
    input  logic [PIDX_W-1:0] pb_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    output logic [DATA_W-1:0] rc_data,
    output logic [DATA_W-1:0] pa_data,
    output logic [DATA_W-1:0] pb_data,
    output logic [DATA_W-1:0] x0_data,
    output logic [DATA_W-1:0] x1_data
);
    logic [DATA_W-1:0] gpr [NUM_GPR];
    logic [DATA_W-1:0] ptr [NUM_PTR];
    logic [DATA_W-1:0] x0_q, x1_q;

    // Register update: reset, then commit, else a load from elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_GPR; i++) gpr[i] <= '0;
            for (int i = 0; i < NUM_PTR; i++) ptr[i] <= '0;
            x0_q <= '0;
            x1_q <= '0;
        end else if (cm_en) begin
            gpr[cm_idx] <= cm_data;
        end else if (ld_en) begin
            if (int'(ld_sel) < SEL_PTR0)
                gpr[ld_sel[RIDX_W-1:0]] <= ld_data;
            else if (int'(ld_sel) < SEL_X0)
                ptr[ld_sel[PIDX_W-1:0]] <= ld_data;
            else if (int'(ld_sel) == SEL_X0)
                x0_q <= ld_data;
            else if (int'(ld_sel) == SEL_X1)
                x1_q <= ld_data;
        end
    end

    // Fixed-index read ports.
    always_comb begin
        ra_data = gpr[ra_idx];
        rb_data = gpr[rb_idx];
        pa_data = ptr[pa_idx];
        pb_data = ptr[pb_idx];
        x0_data = x0_q;
        x1_data = x1_q;
    end

    // Any-register read port over the full select space.
    always_comb begin
        if (int'(rc_sel) < SEL_PTR0)
            rc_data = gpr[rc_sel[RIDX_W-1:0]];
        else if (int'(rc_sel) < SEL_X0)
            rc_data = ptr[rc_sel[PIDX_W-1:0]];
        else if (int'(rc_sel) == SEL_X0)
            rc_data = x0_q;
        else if (int'(rc_sel) == SEL_X1)
            rc_data = x1_q;
        else
            rc_data = '0;
    end
endmodule

// File: rtl/orst_agu.sv
// Indirect address generator: pointer plus a selected displacement.
// Assumes the memory ignores address bits above ADDR_W (wraps modulo).
module orst_agu
    import orst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] x0,
    input  logic [DATA_W-1:0] x1,
    input  disp_sel_e         sel,
    output logic [ADDR_W-1:0] addr
);
    logic [DATA_W-1:0] disp;
    logic [DATA_W-1:0] sum;

    // Displacement select and full-width add.
    always_comb begin
        unique case (sel)
            DISP_ZERO: disp = '0;
            DISP_ONE:  disp = DATA_W'(1);
            DISP_X0:   disp = x0;
            default:   disp = x1;
        endcase
        sum  = base + disp;
        addr = sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/orst_or_unit.sv
// Bitwise OR with zero/negative status held in flops.
// Assumes flags change only on a committing cycle.
module orst_or_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              flag_z,
    output logic              flag_n
);
    // Combinational result.
    always_comb res = a | b;

    // Status capture on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_z <= 1'b0;
            flag_n <= 1'b0;
        end else if (en) begin
            flag_z <= (res == '0);
            flag_n <= res[DATA_W-1];
        end
    end
endmodule

// File: rtl/orst_par_exec.sv
// Single-cycle execute of a parallel OR and integer store.
// Assumes a memory whose read data returns in the same cycle as the
// address and whose write commits at the clock edge; with all operands
// read from flops at cycle start, each side sees pre-commit state.
module orst_par_exec
    import orst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [OPW_W-1:0]  instr,
    input  logic              ld_en,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [DATA_W-1:0] ld_data,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wb_valid,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              flag_z,
    output logic              flag_n
);
    localparam int NUM_PORTS = 2;

    opw_t              ow;
    logic [DATA_W-1:0] s1_val, s3_val, s2_reg, s2_val, or_res;
    logic [DATA_W-1:0] pa_val, pb_val, x0_val, x1_val;
    logic [DATA_W-1:0] agu_base [NUM_PORTS];
    ind_t              agu_ind  [NUM_PORTS];
    logic [ADDR_W-1:0] agu_addr [NUM_PORTS];

    // Field view of the operand word.
    always_comb ow = opw_t'(instr);

    orst_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .cm_en   (issue),
        .cm_idx  (ow.dst1),
        .cm_data (or_res),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_data (ld_data),
        .ra_idx  (ow.src1),
        .rb_idx  (ow.src3),
        .rc_sel  (ow.src2_sel),
        .pa_idx  (ow.rd_ind.ptr),
        .pb_idx  (ow.wr_ind.ptr),
        .ra_data (s1_val),
        .rb_data (s3_val),
        .rc_data (s2_reg),
        .pa_data (pa_val),
        .pb_data (pb_val),
        .x0_data (x0_val),
        .x1_data (x1_val)
    );

    // Per-port operand routing for the address generators.
    always_comb begin
        agu_base[0] = pa_val;
        agu_base[1] = pb_val;
        agu_ind[0]  = ow.rd_ind;
        agu_ind[1]  = ow.wr_ind;
    end

    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_agu
            orst_agu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_agu (
                .base (agu_base[g]),
                .x0   (x0_val),
                .x1   (x1_val),
                .sel  (agu_ind[g].disp),
                .addr (agu_addr[g])
            );
        end
    endgenerate

    // Second OR operand: memory word or any CPU register.
    always_comb s2_val = ow.reg_mode ? s2_reg : mem_rdata;

    orst_or_unit #(.DATA_W(DATA_W)) u_or (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (issue),
        .a      (s1_val),
        .b      (s2_val),
        .res    (or_res),
        .flag_z (flag_z),
        .flag_n (flag_n)
    );

    // Memory and write-back outputs for the execute cycle.
    always_comb begin
        mem_re    = issue && !ow.reg_mode;
        mem_raddr = agu_addr[0];
        mem_we    = issue;
        mem_waddr = agu_addr[1];
        mem_wdata = s3_val;
        wb_valid  = issue;
        wb_idx    = ow.dst1;
        wb_data   = or_res;
    end
endmodule

// File: rtl/orst_checker.sv
// Protocol and status properties for orst_par_exec, attached by bind.
module orst_checker
    import orst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic [OPW_W-1:0]  instr,
    input logic              mem_re,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              wb_valid,
    input logic [DATA_W-1:0] wb_data,
    input logic              flag_z,
    input logic              flag_n
);
    // Result must contain every set bit of the memory operand.
    p_or_covers_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !instr[MODE_BIT] |-> ((wb_data & mem_rdata) == mem_rdata));

    // Register-operand mode suppresses the memory read.
    p_no_read_in_reg_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue && instr[MODE_BIT] |-> !mem_re);

    // Zero flag follows the committed result.
    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (flag_z == ($past(wb_data) == '0)));

    // Negative flag follows the result sign.
    p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (flag_n == $past(wb_data[DATA_W-1])));

    // Idle cycles leave status untouched.
    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |=> ($stable(flag_z) && $stable(flag_n)));
endmodule

bind orst_par_exec orst_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .instr     (instr),
    .mem_re    (mem_re),
    .mem_rdata (mem_rdata),
    .wb_valid  (wb_valid),
    .wb_data   (wb_data),
    .flag_z    (flag_z),
    .flag_n    (flag_n)
);

// File: tb/orst_par_exec_bench.sv
`timescale 1ns/1ps
module orst_par_exec_bench;
    localparam int DW = 32;
    localparam int AW = 10;
    localparam int MW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue = 1'b0;
    logic [24:0]   instr = '0;
    logic          ld_en = 1'b0;
    logic [4:0]    ld_sel = '0;
    logic [DW-1:0] ld_data = '0;
    logic          mem_re, mem_we, wb_valid, flag_z, flag_n;
    logic [AW-1:0] mem_raddr, mem_waddr;
    logic [DW-1:0] mem_rdata, mem_wdata, wb_data;
    logic [2:0]    wb_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    orst_par_exec #(.DATA_W(DW), .ADDR_W(AW)) u_orst_par_exec (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .flag_z(flag_z), .flag_n(flag_n)
    );

    // Memory seen by the design, and an independent reference copy.
    logic [DW-1:0] mem  [MW];
    logic [DW-1:0] rmem [MW];
    assign mem_rdata = mem[mem_raddr];
    always @(posedge clk) if (mem_we) mem[mem_waddr] <= mem_wdata;

    // Reference register state.
    logic [DW-1:0] rg [8];
    logic [DW-1:0] rp [8];
    logic [DW-1:0] rx0, rx1;
    logic          ez, en_;

    function automatic logic [24:0] enc(input int s1, input int d1, input int s3,
                                        input int p2, input int q2, input int pw,
                                        input int qw, input int m, input int r2);
        return {3'(s1), 3'(d1), 3'(s3), 3'(p2), 2'(q2), 3'(pw), 2'(qw), 1'(m), 5'(r2)};
    endfunction

    localparam int NV = 8;
    localparam logic [24:0] VEC [NV] = '{
        enc(1, 2, 3, 0, 0, 1, 1, 0, 0),   // disp 0 / disp 1
        enc(4, 5, 5, 2, 2, 3, 3, 0, 0),   // R3 overlap, disp X0 / X1
        enc(0, 0, 0, 5, 2, 5, 2, 0, 0),   // R4 same address
        enc(3, 4, 2, 0, 0, 6, 2, 1, 17),  // register mode, X1 source
        enc(7, 1, 6, 0, 0, 2, 0, 1, 7),   // zero result
        enc(6, 3, 1, 4, 1, 4, 1, 0, 0),   // negative result, same address
        enc(5, 6, 4, 7, 3, 0, 0, 1, 9),   // register mode, pointer source
        enc(2, 0, 5, 1, 1, 1, 1, 0, 0)    // reads location stored by vector 0
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] cpu_rd(input logic [4:0] s);
        if (s < 8)       return rg[s[2:0]];
        else if (s < 16) return rp[s[2:0]];
        else if (s == 16) return rx0;
        else if (s == 17) return rx1;
        return '0;
    endfunction

    function automatic logic [AW-1:0] ea(input logic [2:0] p, input logic [1:0] q);
        logic [DW-1:0] d;
        case (q)
            2'b00: d = '0;
            2'b01: d = 1;
            2'b10: d = rx0;
            default: d = rx1;
        endcase
        return AW'(rp[p] + d);
    endfunction

    task automatic load(input int sel, input logic [DW-1:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 5'(sel); ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        if (sel < 8) rg[sel] = v;
        else if (sel < 16) rp[sel-8] = v;
        else if (sel == 16) rx0 = v;
        else if (sel == 17) rx1 = v;
    endtask

    // Execute one word; optional load presented in the same cycle (R9).
    task automatic run(input logic [24:0] w, input bit ld, input int lsel,
                       input logic [DW-1:0] ldat);
        logic [2:0] s1, d1, s3;
        logic [AW-1:0] ar, aw;
        logic [DW-1:0] s2, res, sv;
        bit m;
        s1 = w[24:22]; d1 = w[21:19]; s3 = w[18:16]; m = w[5];
        ar = ea(w[15:13], w[12:11]);
        aw = ea(w[10:8], w[7:6]);
        s2 = m ? cpu_rd(w[4:0]) : rmem[ar];
        res = rg[s1] | s2;
        sv = rg[s3];
        @(negedge clk);
        issue = 1'b1; instr = w;
        ld_en = ld; ld_sel = 5'(lsel); ld_data = ldat;
        #1;
        chk("R1 wb_valid", DW'(wb_valid), 1);
        chk("R1/R4 wb_data", wb_data, res);
        chk("R6 wb_idx", DW'(wb_idx), DW'(d1));
        chk("R2/R3 mem_wdata", mem_wdata, sv);
        chk("R2 mem_we", DW'(mem_we), 1);
        chk("R5 mem_waddr", DW'(mem_waddr), DW'(aw));
        chk("R7 mem_re", DW'(mem_re), DW'(!m));
        if (!m) chk("R5 mem_raddr", DW'(mem_raddr), DW'(ar));
        @(negedge clk);
        issue = 1'b0; ld_en = 1'b0;
        rg[d1] = res;
        rmem[aw] = sv;
        ez = (res == '0); en_ = res[DW-1];
        chk("R8 flag_z", DW'(flag_z), DW'(ez));
        chk("R8 flag_n", DW'(flag_n), DW'(en_));
        chk("R4 stored word", mem[aw], sv);
    endtask

    initial begin
        for (int i = 0; i < MW; i++) begin
            mem[i]  = (i * 32'h0100_0193) ^ 32'h5A00_0000;
            rmem[i] = (i * 32'h0100_0193) ^ 32'h5A00_0000;
        end
        for (int i = 0; i < 8; i++) begin rg[i] = '0; rp[i] = '0; end
        rx0 = '0; rx1 = '0;
        repeat (3) @(negedge clk);
        // R10: outputs idle and flags clear in reset
        chk("R10 mem_we", DW'(mem_we), 0);
        chk("R10 wb_valid", DW'(wb_valid), 0);
        chk("R10 flag_z", DW'(flag_z), 0);
        chk("R10 flag_n", DW'(flag_n), 0);
        rst_n = 1'b1;
        // R10: registers read zero after reset (store R4, OR R5 into R6)
        run(enc(5, 6, 4, 0, 0, 0, 1, 0, 0), 0, 0, '0);

        load(0, 32'h0000_00F0); load(1, 32'h1234_0001); load(2, 32'h0F0F_0000);
        load(3, 32'hA5A5_5A5A); load(4, 32'h0000_1000); load(5, 32'h7000_0007);
        load(6, 32'h8000_0000); load(7, 32'h0000_0000);
        for (int i = 0; i < 8; i++) load(8 + i, DW'(i * 53 + 11));
        load(16, 32'd5); load(17, 32'd200);

        for (int v = 0; v < NV; v++) run(VEC[v], 0, 0, '0);

        // R8: idle cycles keep the flags
        begin
            logic fz, fn;
            fz = flag_z; fn = flag_n;
            repeat (3) @(negedge clk);
            chk("R8 hold z", DW'(flag_z), DW'(fz));
            chk("R8 hold n", DW'(flag_n), DW'(fn));
        end

        // R9: load to R6 during an issue is dropped; checked by storing R6
        run(enc(1, 1, 2, 0, 1, 0, 1, 0, 0), 1, 6, 32'hDEAD_BEEF);
        run(enc(0, 3, 6, 2, 0, 3, 0, 0, 0), 0, 0, '0);
        // R9: load to R6 while idle takes effect
        load(6, 32'h0BAD_F00D);
        run(enc(0, 3, 6, 2, 0, 3, 0, 0, 0), 0, 0, '0);
        // R3: store source equals OR destination once more, register mode
        run(enc(6, 6, 6, 0, 0, 2, 1, 1, 16), 0, 0, '0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule